// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port (Master, Half-Duplex)

This block is a byte-wide serial port that moves data in both directions over one open-drain data pin while it drives the shift clock on a second pin. It always acts as master: the shift clock runs only while a transfer is in progress and idles high otherwise. The shift clock is derived from the system clock by a fixed division. Software starts a transmission by writing the data buffer. It arms a reception by setting a receive enable bit while the receive-done flag is clear.

The CPU side is a simple write port with one select bit. Select 0 writes the data buffer. Select 1 writes the control word, whose bit 0 is the receive-done flag, bit 1 the transmit-done flag, bit 2 the receive enable and bit 3 the interrupt enable. The two done flags can be cleared by software but not set by it. The received byte and both flags appear on output ports, and a registered interrupt line is raised while the interrupt is enabled and either flag is set.

Top module: `sync_shift_port`

## Requirements
- R1: A data-buffer write (wr_sel_i=0) accepted while idle starts a transmission. The clock edge that samples the write drives sclk_o low.
- R2: A transmission sends exactly DATA_W bits, least significant bit first. During bit b, sda_drive_low_o is 1 when bit b is 0 and 0 when it is 1. The pin is released (drive-low 0) whenever the port is idle.
- R3: Each bit time lasts CLK_DIV system cycles. sclk_o is low for the first CLK_DIV/2 cycles and high for the rest, so data changes on the falling edge and is sampled on the rising edge. sclk_o is high while idle.
- R4: tx_done_o becomes 1 exactly DATA_W*CLK_DIV cycles after the start edge, at the end of the last bit time, and the port is then idle.
- R5: A reception starts only when the receive enable (control bit 2) is 1 and rx_done_o is 0. While receiving, sda_drive_low_o stays 0.
- R6: A reception samples sda_i on each rising shift-clock edge and assembles the bits least significant bit first. rx_done_o and rx_data_o update one cycle after the last sample. No new reception starts while rx_done_o is 1.
- R7: A data-buffer write while a transfer is in progress is ignored, and the transfer in flight continues unchanged.
- R8: If a data-buffer write and a pending receive condition occur in the same idle cycle, the transmission wins.
- R9: Writing 0 to control bit 0 or bit 1 clears rx_done_o or tx_done_o. Writing 1 to those bits has no effect.
- R10: irq_o equals the interrupt enable (control bit 3) ANDed with (tx_done_o OR rx_done_o).
- R11: A synchronous reset leaves sclk_o high, sda_drive_low_o 0, both flags 0, irq_o 0 and rx_data_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe from the CPU |
| wr_sel_i | input | 1 | 0 selects the data buffer, 1 selects the control word |
| wr_data_i | input | DATA_W | Write data |
| sclk_o | output | 1 | Shift clock, idles high |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls the data pin low |
| sda_i | input | 1 | Data pin level as seen at the pad |
| rx_data_o | output | DATA_W | Last received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the port with its defaults: an eight-bit byte, a divide-by-12 shift clock and a two-stage input synchroniser. At these values a full transmit takes 96 cycles and a receive 91 cycles from start, so every shift-clock edge and every flag transition can be checked cycle by cycle within a short run. Two stages of synchronisation still leave four spare cycles before the sampling edge in each half bit. The bench uses this to hold the pin model's bits for exactly one shift period. Back-to-back writes to the control word and the data buffer place the transmit-versus-receive tie in a single idle cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2
  } shp_mode_e;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

  localparam int CTRL_W     = 4;
  localparam int CB_RX_DONE = 0;
  localparam int CB_TX_DONE = 1;
  localparam int CB_RX_EN   = 2;
  localparam int CB_IRQ_EN  = 3;

endpackage

// File: rtl/shp_baud.sv
module shp_baud #(
  parameter int CLK_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic active_i,
  input  logic hold_high_i,
  output logic rise_stb_o,
  output logic bit_end_o,
  output logic sclk_o
);

  localparam int CW = $clog2(CLK_DIV);
  localparam int HALF = CLK_DIV / 2;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (active_i) begin
      if (cnt_q == FULL_M1) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_stb_o = active_i && (cnt_q == HALF_M1);
  assign bit_end_o  = active_i && (cnt_q == FULL_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
    end else if (start_i) begin
      sclk_q <= 1'b0;
    end else if (rise_stb_o) begin
      sclk_q <= 1'b1;
    end else if (bit_end_o && !hold_high_i) begin
      sclk_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;

  AST_SCLK_FALLS_ON_START: assert property (@(posedge clk) disable iff (rst) start_i |=> !sclk_o); // R1
  AST_SCLK_HIGH_AFTER_RISE: assert property (@(posedge clk) disable iff (rst) rise_stb_o |=> sclk_o); // R3

endmodule

// File: rtl/shp_shift.sv
module shp_shift #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_tx_i,
  input  logic              start_rx_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              tx_active_i,
  input  logic              rx_active_i,
  input  logic              rise_stb_i,
  input  logic              bit_end_i,
  input  logic              last_bit_i,
  input  logic              done_i,
  input  logic              sda_i,
  output logic              drive_low_o,
  output logic [DATA_W-1:0] shreg_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DATA_W-1:0]      sh_q;
  logic                   drv_q;
  logic                   sda_s;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= sda_i;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b1;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign sda_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (start_tx_i) begin
      sh_q <= load_val_i;
    end else if (start_rx_i) begin
      sh_q <= '0;
    end else if (rx_active_i && rise_stb_i) begin
      sh_q <= {sda_s, sh_q[DATA_W-1:1]};
    end else if (tx_active_i && bit_end_i && !last_bit_i) begin
      sh_q <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
    end else if (start_tx_i) begin
      drv_q <= ~load_val_i[0];
    end else if (start_rx_i || done_i) begin
      drv_q <= 1'b0;
    end else if (tx_active_i && bit_end_i) begin
      drv_q <= ~sh_q[1];
    end
  end

  assign drive_low_o = drv_q;
  assign shreg_o     = sh_q;

  AST_RELEASED_IN_RX: assert property (@(posedge clk) disable iff (rst) rx_active_i |-> !drive_low_o); // R5
  AST_RX_SHIFT_IN: assert property (@(posedge clk) disable iff (rst) (rx_active_i && rise_stb_i) |=> (shreg_o[DATA_W-1] == $past(sda_s))); // R6

endmodule

// File: rtl/shp_ctrl.sv
module shp_ctrl
  import shp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_bits_i,
  input  logic              rise_stb_i,
  input  logic              bit_end_i,
  input  logic [DATA_W-1:0] shreg_i,
  output logic              start_tx_o,
  output logic              start_rx_o,
  output logic              idle_o,
  output logic              tx_active_o,
  output logic              rx_active_o,
  output logic              last_bit_o,
  output logic              done_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  shp_mode_e         mode_q;
  logic [BW-1:0]     bit_q;
  logic              rx_last_q;
  logic              tx_done_q, rx_done_q, rx_en_q, irq_en_q, irq_q;
  logic              tx_done_n, rx_done_n, rx_en_n, irq_en_n;
  logic [DATA_W-1:0] rx_data_q;
  logic              tx_fin, rx_fin;

  assign idle_o      = (mode_q == MODE_IDLE);
  assign tx_active_o = (mode_q == MODE_TX);
  assign rx_active_o = (mode_q == MODE_RX);
  assign last_bit_o  = (bit_q == LAST_BIT);

  // a buffer write outranks a pending receive in the same idle cycle
  assign start_tx_o = idle_o && data_wr_i;
  assign start_rx_o = idle_o && !data_wr_i && rx_en_q && !rx_done_q;

  assign tx_fin = tx_active_o && bit_end_i && last_bit_o;
  assign rx_fin = rx_active_o && rx_last_q;
  assign done_o = tx_fin || rx_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
    end else if (start_tx_o) begin
      mode_q <= MODE_TX;
    end else if (start_rx_o) begin
      mode_q <= MODE_RX;
    end else if (done_o) begin
      mode_q <= MODE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
    end else if (start_tx_o || start_rx_o) begin
      bit_q <= '0;
    end else if (!idle_o && bit_end_i && !last_bit_o) begin
      bit_q <= bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_last_q <= 1'b0;
    end else if (start_rx_o || rx_fin) begin
      rx_last_q <= 1'b0;
    end else if (rx_active_o && rise_stb_i && last_bit_o) begin
      rx_last_q <= 1'b1;
    end
  end

  always_comb begin
    tx_done_n = tx_done_q;
    rx_done_n = rx_done_q;
    rx_en_n   = rx_en_q;
    irq_en_n  = irq_en_q;
    if (ctrl_wr_i) begin
      if (!ctrl_bits_i[CB_TX_DONE]) tx_done_n = 1'b0;
      if (!ctrl_bits_i[CB_RX_DONE]) rx_done_n = 1'b0;
      rx_en_n  = ctrl_bits_i[CB_RX_EN];
      irq_en_n = ctrl_bits_i[CB_IRQ_EN];
    end
    if (tx_fin) tx_done_n = 1'b1;
    if (rx_fin) rx_done_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_en_q   <= 1'b0;
      irq_en_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      tx_done_q <= tx_done_n;
      rx_done_q <= rx_done_n;
      rx_en_q   <= rx_en_n;
      irq_en_q  <= irq_en_n;
      irq_q     <= irq_en_n && (tx_done_n || rx_done_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rx_data_q <= '0;
    else if (rx_fin) rx_data_q <= shreg_i;
  end

  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
  assign irq_o     = irq_q;
  assign rx_data_o = rx_data_q;

  AST_TX_DONE_FROM_TX: assert property (@(posedge clk) disable iff (rst) $rose(tx_done_q) |-> ($past(mode_q) == MODE_TX)); // R4
  AST_NO_RX_WHILE_DONE: assert property (@(posedge clk) disable iff (rst) (idle_o && rx_done_q) |=> (mode_q != MODE_RX)); // R6
  AST_RX_DATA_STABLE: assert property (@(posedge clk) disable iff (rst) (rx_done_q && $past(rx_done_q)) |-> $stable(rx_data_q)); // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst) (rx_active_o && !rx_fin && data_wr_i) |=> (mode_q == MODE_RX)); // R7
  AST_TX_WINS: assert property (@(posedge clk) disable iff (rst) (idle_o && data_wr_i) |=> (mode_q == MODE_TX)); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) irq_q == (irq_en_q && (tx_done_q || rx_done_q))); // R10

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import shp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sclk_o,
  output logic              sda_drive_low_o,
  input  logic              sda_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              irq_o
);

  initial begin
    if (DATA_W < CTRL_W) $error("DATA_W must hold the control word");
    if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) $error("CLK_DIV must be even and at least 4");
    if (SYNC_STAGES < 1 || SYNC_STAGES > (CLK_DIV / 2) - 2) $error("SYNC_STAGES out of range");
  end

  logic data_wr, ctrl_wr;
  logic start_tx, start_rx, idle, tx_active, rx_active, last_bit, done;
  logic rise_stb, bit_end;
  logic [DATA_W-1:0] shreg;

  assign data_wr = wr_en_i && (wr_sel_i == SEL_DATA);
  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);

  shp_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .data_wr_i   (data_wr),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_bits_i (wr_data_i[CTRL_W-1:0]),
    .rise_stb_i  (rise_stb),
    .bit_end_i   (bit_end),
    .shreg_i     (shreg),
    .start_tx_o  (start_tx),
    .start_rx_o  (start_rx),
    .idle_o      (idle),
    .tx_active_o (tx_active),
    .rx_active_o (rx_active),
    .last_bit_o  (last_bit),
    .done_o      (done),
    .tx_done_o   (tx_done_o),
    .rx_done_o   (rx_done_o),
    .irq_o       (irq_o),
    .rx_data_o   (rx_data_o)
  );

  shp_baud #(.CLK_DIV(CLK_DIV)) baud_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_tx || start_rx),
    .active_i    (!idle),
    .hold_high_i (tx_active && last_bit),
    .rise_stb_o  (rise_stb),
    .bit_end_o   (bit_end),
    .sclk_o      (sclk_o)
  );

  shp_shift #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) shift_i (
    .clk         (clk),
    .rst         (rst),
    .start_tx_i  (start_tx),
    .start_rx_i  (start_rx),
    .load_val_i  (wr_data_i),
    .tx_active_i (tx_active),
    .rx_active_i (rx_active),
    .rise_stb_i  (rise_stb),
    .bit_end_i   (bit_end),
    .last_bit_i  (last_bit),
    .done_i      (done),
    .sda_i       (sda_i),
    .drive_low_o (sda_drive_low_o),
    .shreg_o     (shreg)
  );

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) idle |-> sclk_o); // R3
  AST_PIN_RELEASED_IDLE: assert property (@(posedge clk) disable iff (rst) idle |-> !sda_drive_low_o); // R2

endmodule

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;

  localparam int DW = 8;
  localparam int DIV = 12;
  localparam int HALF = DIV / 2;
  localparam int TX_LEN = DW * DIV;
  localparam int RX_LEN = (DW - 1) * DIV + HALF + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic sclk, drv, sda_pin, slave_bit = 1'b1;
  logic [DW-1:0] rx_data;
  logic tx_done, rx_done, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign sda_pin = !drv && slave_bit;

  sync_shift_port #(.DATA_W(DW), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sclk_o(sclk), .sda_drive_low_o(drv), .sda_i(sda_pin), .rx_data_o(rx_data),
    .tx_done_o(tx_done), .rx_done_o(rx_done), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // control word: bit0 rx_done, bit1 tx_done, bit2 rx_en, bit3 irq_en
  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = DW'(v);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_tx(input logic [DW-1:0] b, input int busy_wr_at, input string tag);
    int err_s = 0;
    int err_d = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = b;
    @(posedge clk);
    #1 wr_en = 1'b0;
    for (int k = 0; k < TX_LEN; k++) begin
      @(negedge clk);
      if (k == busy_wr_at) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = ~b; end
      if (k == busy_wr_at + 1) wr_en = 1'b0;
      if (sclk !== ((k % DIV) >= HALF)) err_s++;
      if (drv !== !b[k / DIV]) err_d++;
      if (k == 0) chk(sclk === 1'b0, "R1", {tag, " sclk low after start"}, sclk, 0);
      if (k == TX_LEN - 1) chk(tx_done === 1'b0, "R4", {tag, " tx_done before end"}, tx_done, 0);
    end
    chk(err_s == 0, "R3", {tag, " sclk waveform mismatches"}, err_s, 0);
    chk(err_d == 0, "R2", {tag, " data waveform mismatches"}, err_d, 0);
    @(negedge clk);
    chk(tx_done === 1'b1, "R4", {tag, " tx_done at end"}, tx_done, 1);
    chk(sclk === 1'b1 && drv === 1'b0, "R2", {tag, " idle pins after tx"}, {sclk, drv}, 2);
  endtask

  task automatic slave_send(input logic [DW-1:0] b);
    for (int i = 0; i < DW; i++) begin
      @(negedge sclk);
      slave_bit = b[i];
    end
    @(posedge sclk);
    @(negedge clk);
    slave_bit = 1'b1;
  endtask

  task automatic do_rx(input logic [DW-1:0] b, input logic [3:0] ctrl_v, input string tag);
    int err_d = 0;
    fork
      slave_send(b);
      begin
        wr_ctrl(ctrl_v);
        for (int j = 0; j <= RX_LEN; j++) begin
          @(negedge clk);
          if (drv !== 1'b0) err_d++;
          if (j == 1) chk(sclk === 1'b0, "R5", {tag, " rx started"}, sclk, 0);
          if (j == RX_LEN) chk(rx_done === 1'b0, "R6", {tag, " rx_done early"}, rx_done, 0);
        end
        @(negedge clk);
        chk(rx_done === 1'b1, "R6", {tag, " rx_done set"}, rx_done, 1);
        chk(rx_data === b, "R6", {tag, " rx byte"}, rx_data, b);
        chk(err_d == 0, "R5", {tag, " pin driven during rx"}, err_d, 0);
      end
    join
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sclk === 1'b1 && drv === 1'b0, "R11", "pins after reset", {sclk, drv}, 2);
    chk(tx_done === 1'b0 && rx_done === 1'b0 && irq === 1'b0, "R11", "flags after reset", {tx_done, rx_done, irq}, 0);
    chk(rx_data === '0, "R11", "rx_data after reset", rx_data, 0);
    rst = 1'b0;
  endtask

  task automatic t_tx_and_flags();
    do_tx(8'hA5, -1, "tx A5");
    chk(irq === 1'b0, "R10", "irq masked", irq, 0);
    wr_ctrl(4'b1010);
    @(negedge clk);
    chk(tx_done === 1'b1, "R9", "write 1 keeps tx_done", tx_done, 1);
    chk(irq === 1'b1, "R10", "irq enabled with tx_done", irq, 1);
    wr_ctrl(4'b1000);
    @(negedge clk);
    chk(tx_done === 1'b0, "R9", "write 0 clears tx_done", tx_done, 0);
    chk(irq === 1'b0, "R10", "irq drops with flags clear", irq, 0);
    do_tx(8'h3C, -1, "tx 3C");
    wr_ctrl(4'b0000);
  endtask

  task automatic t_rx();
    int err_s = 0;
    repeat (40) begin
      @(negedge clk);
      if (sclk !== 1'b1) err_s++;
    end
    chk(err_s == 0, "R5", "no rx while disabled", err_s, 0);
    do_rx(8'h96, 4'b1100, "rx 96");
    chk(irq === 1'b1, "R10", "irq with rx_done", irq, 1);
    err_s = 0;
    repeat (100) begin
      @(negedge clk);
      if (sclk !== 1'b1) err_s++;
    end
    chk(err_s == 0, "R6", "stalled while rx_done set", err_s, 0);
    chk(rx_data === 8'h96, "R6", "rx byte held", rx_data, 8'h96);
    do_rx(8'h0F, 4'b0100, "rx 0F after clear");
    wr_ctrl(4'b0000);
    @(negedge clk);
    chk(rx_done === 1'b0, "R9", "write 0 clears rx_done", rx_done, 0);
  endtask

  task automatic t_busy_write();
    int err_s = 0;
    do_tx(8'hFF, 30, "tx FF busy write R7");
    repeat (40) begin
      @(negedge clk);
      if (sclk !== 1'b1) err_s++;
    end
    chk(err_s == 0, "R7", "no second transfer", err_s, 0);
    wr_ctrl(4'b0000);
  endtask

  task automatic t_priority();
    int n = 0;
    wr_ctrl(4'b0100);
    do_tx(8'h81, -1, "tx 81 priority R8");
    while (rx_done !== 1'b1 && n < 150) begin
      @(negedge clk);
      n++;
    end
    chk(n == RX_LEN + 1, "R8", "rx follows tx, cycles", n, RX_LEN + 1);
    chk(rx_data === 8'hFF, "R6", "released pin reads ones", rx_data, 8'hFF);
    wr_ctrl(4'b0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_and_flags();
    t_rx();
    t_busy_write();
    t_priority();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule